// File: doc/BRIEF.md
# Port Clock Pacer with Edge Counter

This block paces a group of I/O ports. It runs entirely in a fast core clock domain. It chooses one of two timing sources. The first is a reference whose edges arrive as one-cycle pulses on `ref_edge_i`; a programmable divider slows it down. The second is an external clock pin, which is resynchronised by a flop chain and then edge-detected. From the chosen source the block keeps a clock level, and it emits one-cycle rise and fall ticks. The ports attached to it use these ticks as clock enables.

The block also keeps a single 16-bit edge counter, which every attached port reads for timestamps and timed transfers. Because all ports read this one register, they always see the same count. When an external source runs irregularly, the counter holds a number of edges and not a measure of time. The block also samples a ready strobe at each rising edge of the selected clock and hands the sampled value to the ports. The `run_i` input freezes or releases the whole timebase.

Top module: `port_clk_pacer`

## Requirements
- R1: After a synchronous reset, `clk_lvl_o`, `rise_tick_o`, `fall_tick_o`, `ready_o` are 0 and `edge_cnt_o` is 0x0000.
- R2: With the reference source (`src_ext_i`=0) and divide value D in 1..255, `clk_lvl_o` toggles once per 2·D reference edge pulses, so its frequency is the reference frequency divided by 2·D.
- R3: With D=0 the divider is bypassed and `clk_lvl_o` toggles on every reference edge pulse.
- R4: With the external source (`src_ext_i`=1), `clk_lvl_o` follows `ext_clk_i` through the synchroniser, and each full high/low pulse on the pin yields exactly one rise tick and one fall tick.
- R5: `rise_tick_o` (`fall_tick_o`) is high for exactly the one cycle in which `clk_lvl_o` goes 0→1 (1→0); the two ticks are never high together.
- R6: `edge_cnt_o` increases by exactly one in the cycle of each fall tick and is otherwise unchanged.
- R7: The counter wraps from 0xFFFF to 0x0000 on the next fall tick, with no other indication.
- R8: While `run_i` is 0, reference and external edges are ignored: `clk_lvl_o` and `edge_cnt_o` hold, no ticks are produced, and the divider phase restarts from zero when `run_i` returns to 1.
- R9: `ready_o` takes the synchronised `ready_i` value only in the cycle of a rise tick and holds it at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast core clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 lets the timebase advance, 0 freezes it |
| src_ext_i | input | 1 | 0 selects the divided reference, 1 selects the external pin |
| div_i | input | 8 | Divide value D (0 = bypass) |
| ref_edge_i | input | 1 | One-cycle pulse for each reference clock edge |
| ext_clk_i | input | 1 | External clock pin (asynchronous) |
| ready_i | input | 1 | Ready strobe from outside (asynchronous) |
| clk_lvl_o | output | 1 | Selected clock level, suitable to drive a clock-output pin |
| rise_tick_o | output | 1 | One-cycle enable on the clock's rising edge |
| fall_tick_o | output | 1 | One-cycle enable on the clock's falling edge |
| edge_cnt_o | output | 16 | Shared port counter |
| ready_o | output | 1 | Ready strobe sampled at the last rising edge |

## Verification
The hardest condition to reach from the ports is the counter wrap, because it needs 65,536 falling edges. The bench reaches it by selecting bypass mode and holding the reference pulse high on every cycle. This gives one falling edge every two core cycles, so the counter reaches 0xFFFF within about 131k cycles. The bench then checks the value after the next fall tick. It also checks the ready capture by changing the strobe while no edges arrive, and it checks the freeze by sending edges while `run_i` is low.

// File: rtl/port_clk_pacer_pkg.sv
package port_clk_pacer_pkg;
  typedef enum logic {
    SRC_REF = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } tick_t;
endpackage

// File: rtl/pacer_sync.sv
module pacer_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pacer_ref_div.sv
module pacer_ref_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             ref_edge_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             lvl_o
);
  localparam int PH_W = DIV_W + 1;

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] limit;
  logic            bypass;
  logic            lvl_q;

  assign bypass = (div_i == '0);
  assign limit  = {div_i, 1'b0} - PH_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      lvl_q   <= 1'b0;
    end else if (!run_i) begin
      phase_q <= '0;
    end else if (ref_edge_i) begin
      if (bypass || phase_q >= limit) begin
        phase_q <= '0;
        lvl_q   <= ~lvl_q;
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/pacer_edge_count.sv
module pacer_edge_count
  import port_clk_pacer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             lvl_i,
  input  logic             rdy_sync_i,
  output tick_t            tick_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rdy_o
);
  logic             lvl_q, rise_q, fall_q, rdy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise_now, fall_now;

  assign rise_now = run_i && !lvl_q &&  lvl_i;
  assign fall_now = run_i &&  lvl_q && !lvl_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      cnt_q  <= '0;
      rdy_q  <= 1'b0;
    end else begin
      rise_q <= rise_now;
      fall_q <= fall_now;
      if (run_i)    lvl_q <= lvl_i;
      if (fall_now) cnt_q <= cnt_q + CNT_W'(1);
      if (rise_now) rdy_q <= rdy_sync_i;
    end
  end

  assign tick_o = '{lvl: lvl_q, rise: rise_q, fall: fall_q};
  assign cnt_o  = cnt_q;
  assign rdy_o  = rdy_q;
endmodule

// File: rtl/port_clk_pacer.sv
module port_clk_pacer
  import port_clk_pacer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             src_ext_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ref_edge_i,
  input  logic             ext_clk_i,
  input  logic             ready_i,
  output logic             clk_lvl_o,
  output logic             rise_tick_o,
  output logic             fall_tick_o,
  output logic [CNT_W-1:0] edge_cnt_o,
  output logic             ready_o
);
  localparam int NSYNC = 2;

  clk_src_e   src;
  logic [NSYNC-1:0] pins_sync;
  logic       ref_lvl;
  logic       sel_lvl;
  tick_t      tick;

  assign src = clk_src_e'(src_ext_i);

  pacer_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ready_i, ext_clk_i}),
    .sync_o  (pins_sync)
  );

  pacer_ref_div #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run_i),
    .ref_edge_i (ref_edge_i),
    .div_i      (div_i),
    .lvl_o      (ref_lvl)
  );

  assign sel_lvl = (src == SRC_EXT) ? pins_sync[0] : ref_lvl;

  pacer_edge_count #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run_i),
    .lvl_i      (sel_lvl),
    .rdy_sync_i (pins_sync[1]),
    .tick_o     (tick),
    .cnt_o      (edge_cnt_o),
    .rdy_o      (ready_o)
  );

  assign clk_lvl_o   = tick.lvl;
  assign rise_tick_o = tick.rise;
  assign fall_tick_o = tick.fall;
endmodule

// File: rtl/port_clk_pacer_chk.sv
module port_clk_pacer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run_i,
  input logic             clk_lvl_o,
  input logic             rise_tick_o,
  input logic             fall_tick_o,
  input logic [CNT_W-1:0] edge_cnt_o,
  input logic             ready_o
);
  AST_TICK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rise_tick_o && fall_tick_o)); // R5

  AST_RISE_LVL: assert property (@(posedge clk) disable iff (rst)
    rise_tick_o |-> (clk_lvl_o && !$past(clk_lvl_o))); // R5

  AST_FALL_LVL: assert property (@(posedge clk) disable iff (rst)
    fall_tick_o |-> (!clk_lvl_o && $past(clk_lvl_o))); // R5

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    fall_tick_o |-> (edge_cnt_o == $past(edge_cnt_o) + CNT_W'(1))); // R6

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fall_tick_o |-> $stable(edge_cnt_o)); // R6

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !$past(run_i) |-> ($stable(clk_lvl_o) && !rise_tick_o && !fall_tick_o)); // R8

  AST_RDY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !rise_tick_o |-> $stable(ready_o)); // R9
endmodule

bind port_clk_pacer port_clk_pacer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run_i       (run_i),
  .clk_lvl_o   (clk_lvl_o),
  .rise_tick_o (rise_tick_o),
  .fall_tick_o (fall_tick_o),
  .edge_cnt_o  (edge_cnt_o),
  .ready_o     (ready_o)
);

// File: tb/port_clk_pacer_test.sv
`timescale 1ns/1ps
module port_clk_pacer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_i = 1'b0;
  logic        src_ext_i = 1'b0;
  logic [7:0]  div_i = 8'd1;
  logic        ref_edge_i = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic        ready_i = 1'b0;
  logic        clk_lvl_o, rise_tick_o, fall_tick_o, ready_o;
  logic [15:0] edge_cnt_o;

  int total = 0;
  int bad = 0;
  int rises = 0;
  int falls = 0;
  logic clr_ticks = 1'b0;

  always #4 clk = ~clk;

  port_clk_pacer uut (
    .clk(clk), .rst(rst), .run_i(run_i), .src_ext_i(src_ext_i),
    .div_i(div_i), .ref_edge_i(ref_edge_i), .ext_clk_i(ext_clk_i),
    .ready_i(ready_i), .clk_lvl_o(clk_lvl_o), .rise_tick_o(rise_tick_o),
    .fall_tick_o(fall_tick_o), .edge_cnt_o(edge_cnt_o), .ready_o(ready_o)
  );

  always @(negedge clk) begin
    if (clr_ticks) begin
      rises <= 0;
      falls <= 0;
    end else begin
      if (rise_tick_o) rises <= rises + 1;
      if (fall_tick_o) falls <= falls + 1;
    end
  end

  typedef struct packed {
    logic        ext;
    logic [7:0]  div;
    logic [11:0] n;
    logic [15:0] cnt;
    logic        lvl;
    logic [7:0]  rises;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b0, 8'd1,   12'd8,    16'd2, 1'b0, 8'd2},  // R2
    '{1'b0, 8'd3,   12'd20,   16'd1, 1'b1, 8'd2},  // R2
    '{1'b0, 8'd0,   12'd7,    16'd3, 1'b1, 8'd4},  // R3
    '{1'b0, 8'd2,   12'd3,    16'd0, 1'b0, 8'd0},  // R2
    '{1'b1, 8'd0,   12'd5,    16'd5, 1'b0, 8'd5},  // R4
    '{1'b0, 8'd255, 12'd1020, 16'd1, 1'b0, 8'd1},  // R2
    '{1'b1, 8'd9,   12'd2,    16'd2, 1'b0, 8'd2}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); rst <= 1'b1; run_i <= 1'b0;
    ref_edge_i <= 1'b0; ext_clk_i <= 1'b0; ready_i <= 1'b0;
    clr_ticks <= 1'b1;
    repeat (3) @(posedge clk);
    rst <= 1'b0; clr_ticks <= 1'b0;
    @(posedge clk);
  endtask

  task automatic ref_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); ref_edge_i <= 1'b1;
      @(posedge clk); ref_edge_i <= 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); ext_clk_i <= 1'b1;
      repeat (4) @(posedge clk);
      ext_clk_i <= 1'b0;
      repeat (4) @(posedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 lvl", clk_lvl_o, 0);
    check("R1 rise", rise_tick_o, 0);
    check("R1 fall", fall_tick_o, 0);
    check("R1 cnt", edge_cnt_o, 0);
    check("R1 ready", ready_o, 0);

    // table of vectors (R2, R3, R4, R5, R6)
    for (int v = 0; v < 7; v++) begin
      do_reset();
      src_ext_i <= VEC[v].ext;
      div_i     <= VEC[v].div;
      run_i     <= 1'b1;
      @(posedge clk);
      if (VEC[v].ext) ext_pulses(int'(VEC[v].n));
      else            ref_pulses(int'(VEC[v].n));
      repeat (6) @(posedge clk);
      @(negedge clk);
      check(VEC[v].ext ? "R4 cnt" : (VEC[v].div == 0 ? "R3 cnt" : "R2 cnt"),
            edge_cnt_o, VEC[v].cnt);
      check(VEC[v].ext ? "R4 lvl" : (VEC[v].div == 0 ? "R3 lvl" : "R2 lvl"),
            clk_lvl_o, VEC[v].lvl);
      check("R5 rise count", rises, VEC[v].rises);
      check("R6 fall count", falls, VEC[v].cnt);
    end

    // R8: stopped block ignores edges, and divider phase restarts
    do_reset();
    src_ext_i <= 1'b0; div_i <= 8'd2; run_i <= 1'b1;
    ref_pulses(8);              // 2 toggles -> one fall, lvl 0
    ref_pulses(3);              // phase 3 of 4
    run_i <= 1'b0;
    ref_pulses(9);
    @(negedge clk);
    check("R8 cnt frozen", edge_cnt_o, 1);
    check("R8 lvl frozen", clk_lvl_o, 0);
    check("R8 no ticks", rises, 2'd1);
    src_ext_i <= 1'b1;
    ext_pulses(2);
    @(negedge clk);
    check("R8 ext ignored", edge_cnt_o, 1);
    src_ext_i <= 1'b0;
    run_i <= 1'b1;
    ref_pulses(3);              // phase restarted: no toggle yet
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 phase restart", clk_lvl_o, 0);
    ref_pulses(1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 resumes", clk_lvl_o, 1);

    // R9: ready captured only on rising edge
    do_reset();
    src_ext_i <= 1'b0; div_i <= 8'd1; run_i <= 1'b1;
    ready_i <= 1'b1;
    repeat (5) @(posedge clk);
    ref_pulses(2);              // rise
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 captured high", ready_o, 1);
    ready_i <= 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R9 held between rises", ready_o, 1);
    ref_pulses(2);              // fall
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 not taken on fall", ready_o, 1);
    ref_pulses(2);              // rise
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 captured low", ready_o, 0);

    // R7: wrap using bypass with continuous reference pulses
    do_reset();
    src_ext_i <= 1'b0; div_i <= 8'd0; run_i <= 1'b1;
    ref_edge_i <= 1'b1;
    @(negedge clk);
    while (edge_cnt_o != 16'hFFFF) @(negedge clk);
    check("R7 reached max", edge_cnt_o, 16'hFFFF);
    @(negedge clk);
    while (!fall_tick_o) @(negedge clk);
    check("R7 wrap to zero", edge_cnt_o, 16'h0000);
    ref_edge_i <= 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule